// File: doc/BRIEF.md
# Pipelined Parametric FIR Filter

This block is a finite impulse response filter whose tap count, coefficient width and sample width are all parameters. Each accepted signed sample enters a cascade of tap registers. Every tap value is multiplied by its own signed coefficient in a bank of registered multipliers. A registered pairwise adder tree then sums the products. The result is a signed, full-precision output word with no rounding and no truncation. The coefficients arrive as one flat input bus. They are expected to stay constant while samples are in flight.

Samples flow in and results flow out over valid/ready handshakes. The whole pipeline advances as one unit, in any cycle where the output register is empty or is being read. When the output holds a result that the consumer has not taken, every stage freezes, including the tap cascade, and the input reports not ready. A sample is accepted on a rising edge where both `in_valid` and `in_ready` are high. A result is delivered on a rising edge where both `out_valid` and `out_ready` are high. Cycles without an accepted sample travel down the pipeline as bubbles and never reach the output as valid words.

Top module: `pfir_top`

## Requirements
- R1: A synchronous active-high `rst` empties the pipeline. `out_valid` is low in the cycle after reset. The tap history is cleared, so after reset the filter behaves as though every earlier sample were zero.
- R2: For the n-th accepted sample, the delivered result equals the sum over k = 0..N_TAPS-1 of c[k]·x[n-k]. Here x[n] is the newest accepted sample and c[k] is the signed value at `coef` bits [k·COEF_W +: COEF_W]. Results leave in the order the samples were accepted.
- R3: While `out_ready` stays high, the result for a sample accepted at clock edge E appears, with `out_valid` high, right after edge E + 1 + ceil(log2(N_TAPS)). That is 2 + ceil(log2(N_TAPS)) edges in total: one for the tap, one for the product, and one per adder level.
- R4: `out_data` is two's complement and DATA_W + COEF_W + ceil(log2(N_TAPS)) bits wide. Extreme inputs never overflow. With N_TAPS = 5, every sample at -128 and every coefficient at -128 gives +81920.
- R5: A cycle with `in_valid` low does not shift the taps and adds no valid output word. The data on `in_data` in such a cycle has no effect on any result.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values into the next cycle, and no result is lost or repeated.
- R7: `in_ready` is high exactly when `out_ready` is high or `out_valid` is low.
- R8: A single accepted sample of value 1 with zeros around it produces the coefficients c[0], c[1], ..., c[N_TAPS-1] as consecutive results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample on `in_data` is offered |
| in_ready | output | 1 | Pipeline can accept a sample this cycle |
| in_data | input | DATA_W | Signed input sample |
| coef | input | N_TAPS·COEF_W | Flat signed coefficient bus, c[k] at bits [k·COEF_W +: COEF_W] |
| out_valid | output | 1 | `out_data` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | DATA_W+COEF_W+ceil(log2(N_TAPS)) | Signed full-precision filter result |

## Verification
With the default five taps the adder tree has three levels, so a result is due five edges after its sample is accepted. The bench stamps each accepted sample with its cycle index. It checks that the matching result is seen exactly five steps later whenever the consumer stays ready. Under back-pressure the latency check is switched off. Delivery order and held values are still compared, and every probe is taken one time unit after the falling edge, so all registered outputs have settled.

// File: rtl/pfir_pkg.sv
package pfir_pkg;

  // Number of registered adder levels needed to reduce n products to one.
  function automatic int unsigned tree_levels(input int unsigned n);
    return (n <= 32'd1) ? 32'd0 : $clog2(n);
  endfunction

  // Number of nodes present at a given level of the pairwise tree.
  function automatic int unsigned nodes_at(input int unsigned n, input int unsigned lvl);
    return (n + (32'd1 << lvl) - 32'd1) >> lvl;
  endfunction

endpackage

// File: rtl/pfir_tap_line.sv
module pfir_tap_line #(
  parameter int unsigned N_TAPS = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       shift,
  input  logic [DATA_W-1:0]          sample_i,
  output logic [N_TAPS*DATA_W-1:0]   taps_o
);

  logic [DATA_W-1:0] stage_q [N_TAPS];

  // Stage 0 already holds one register of delay; stage k holds k+1.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < int'(N_TAPS); k++) stage_q[k] <= '0;
    end else if (shift) begin
      stage_q[0] <= sample_i;
      for (int k = 1; k < int'(N_TAPS); k++) stage_q[k] <= stage_q[k-1];
    end
  end

  for (genvar k = 0; k < int'(N_TAPS); k++) begin : g_out
    assign taps_o[k*DATA_W +: DATA_W] = stage_q[k];
  end

endmodule

// File: rtl/pfir_mul_bank.sv
module pfir_mul_bank #(
  parameter int unsigned N_TAPS = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adv,
  input  logic [N_TAPS*DATA_W-1:0]   taps_i,
  input  logic [N_TAPS*COEF_W-1:0]   coef_i,
  output logic [N_TAPS*PROD_W-1:0]   prods_o
);

  for (genvar k = 0; k < int'(N_TAPS); k++) begin : g_mul
    logic [DATA_W-1:0]        tap_v;
    logic [COEF_W-1:0]        cf_v;
    logic signed [PROD_W-1:0] tap_x;
    logic signed [PROD_W-1:0] cf_x;
    logic signed [PROD_W-1:0] prod_q;

    assign tap_v = taps_i[k*DATA_W +: DATA_W];
    assign cf_v  = coef_i[k*COEF_W +: COEF_W];
    // Explicit sign extension to the full product width.
    assign tap_x = $signed({{COEF_W{tap_v[DATA_W-1]}}, tap_v});
    assign cf_x  = $signed({{DATA_W{cf_v[COEF_W-1]}}, cf_v});

    always_ff @(posedge clk) begin
      if (rst)      prod_q <= '0;
      else if (adv) prod_q <= tap_x * cf_x;
    end

    assign prods_o[k*PROD_W +: PROD_W] = prod_q;
  end

endmodule

// File: rtl/pfir_add_tree.sv
module pfir_add_tree #(
  parameter int unsigned N_IN = 5,
  parameter int unsigned IN_W = 16,
  localparam int unsigned LEVELS = pfir_pkg::tree_levels(N_IN),
  localparam int unsigned OUT_W  = IN_W + LEVELS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic [N_IN*IN_W-1:0]   leaves_i,
  output logic [OUT_W-1:0]       sum_o
);

  // Level l has nodes_at(N_IN, l) nodes, each IN_W + l bits wide.
  for (genvar l = 0; l <= int'(LEVELS); l++) begin : g_lvl
    localparam int unsigned CUR = pfir_pkg::nodes_at(N_IN, l);
    localparam int unsigned NW  = IN_W + l;

    for (genvar j = 0; j < int'(CUR); j++) begin : g_nd
      logic [NW-1:0] val;

      if (l == 0) begin : g_leaf
        assign val = leaves_i[j*IN_W +: IN_W];
      end else begin : g_sum
        localparam int unsigned PREV = pfir_pkg::nodes_at(N_IN, l - 1);
        logic [NW-1:0] lhs;
        logic [NW-1:0] rhs;
        logic [NW-1:0] acc_q;

        assign lhs = {g_lvl[l-1].g_nd[2*j].val[NW-2], g_lvl[l-1].g_nd[2*j].val};
        if (2*j + 1 < int'(PREV)) begin : g_pair
          assign rhs = {g_lvl[l-1].g_nd[2*j+1].val[NW-2], g_lvl[l-1].g_nd[2*j+1].val};
        end else begin : g_odd
          // Odd leftover: registered and widened so it stays aligned.
          assign rhs = '0;
        end

        always_ff @(posedge clk) begin
          if (rst)      acc_q <= '0;
          else if (adv) acc_q <= lhs + rhs;
        end

        assign val = acc_q;
      end
    end
  end

  assign sum_o = g_lvl[LEVELS].g_nd[0].val;

endmodule

// File: rtl/pfir_top.sv
module pfir_top #(
  parameter int unsigned N_TAPS = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 8
) (
  input  logic                                                          clk,
  input  logic                                                          rst,
  input  logic                                                          in_valid,
  output logic                                                          in_ready,
  input  logic [DATA_W-1:0]                                             in_data,
  input  logic [N_TAPS*COEF_W-1:0]                                      coef,
  output logic                                                          out_valid,
  input  logic                                                          out_ready,
  output logic [DATA_W+COEF_W+pfir_pkg::tree_levels(N_TAPS)-1:0]        out_data
);

  localparam int unsigned LEVELS = pfir_pkg::tree_levels(N_TAPS);
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned OUT_W  = PROD_W + LEVELS;
  localparam int unsigned LAT    = 2 + LEVELS;

  logic                       adv;
  logic [N_TAPS*DATA_W-1:0]   taps;
  logic [N_TAPS*PROD_W-1:0]   prods;
  logic [LAT-1:0]             vld_q;

  // Whole pipeline moves together whenever the output slot can change.
  assign adv      = out_ready || !vld_q[LAT-1];
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst)      vld_q <= '0;
    else if (adv) vld_q <= {vld_q[LAT-2:0], in_valid};
  end

  pfir_tap_line #(
    .N_TAPS (N_TAPS),
    .DATA_W (DATA_W)
  ) u_taps (
    .clk      (clk),
    .rst      (rst),
    .shift    (adv && in_valid),
    .sample_i (in_data),
    .taps_o   (taps)
  );

  pfir_mul_bank #(
    .N_TAPS (N_TAPS),
    .DATA_W (DATA_W),
    .COEF_W (COEF_W)
  ) u_mul (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .taps_i  (taps),
    .coef_i  (coef),
    .prods_o (prods)
  );

  logic [OUT_W-1:0] tree_sum;

  pfir_add_tree #(
    .N_IN (N_TAPS),
    .IN_W (PROD_W)
  ) u_tree (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .leaves_i (prods),
    .sum_o    (tree_sum)
  );

  assign out_valid = vld_q[LAT-1];
  assign out_data  = tree_sum;

endmodule

// File: rtl/pfir_chk.sv
module pfir_chk #(
  parameter int unsigned OUT_W = 19,
  parameter int unsigned LAT   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);

  logic [15:0] inflight_q;

  always_ff @(posedge clk) begin
    if (rst) inflight_q <= '0;
    else inflight_q <= inflight_q
                       + 16'(in_valid && in_ready)
                       - 16'(out_valid && out_ready);
  end

  // R1
  reset_empties_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  ready_passes_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  // R5
  valid_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight_q != 16'd0));

  // R3
  inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
    inflight_q <= 16'(LAT));

endmodule

bind pfir_top pfir_chk #(
  .OUT_W (OUT_W),
  .LAT   (LAT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_pfir_top.sv
module sim_pfir_top;
  localparam int N   = 5;
  localparam int DW  = 8;
  localparam int CW  = 8;
  localparam int LV  = $clog2(N);
  localparam int OW  = DW + CW + LV;
  localparam int LAT = 2 + LV;

  logic              clk;
  logic              rst;
  logic              in_valid;
  logic              in_ready;
  logic [DW-1:0]     in_data;
  logic [N*CW-1:0]   coef;
  logic              out_valid;
  logic              out_ready;
  logic [OW-1:0]     out_data;

  pfir_top #(.N_TAPS(N), .DATA_W(DW), .COEF_W(CW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .coef(coef), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int      cf [N];
  longint  hist [N];
  longint  exp_q [$];
  int      cyc_q [$];
  int      cyc;
  int      n_chk;
  int      n_bad;
  bit      lat_on;
  bit      prev_stall;
  logic [OW-1:0] prev_data;
  string   cur_req;
  bit      done;

  always_comb begin
    for (int k = 0; k < N; k++) coef[k*CW +: CW] = cf[k][CW-1:0];
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < N; k++) hist[k] = 0;
    exp_q.delete();
    cyc_q.delete();
    prev_stall = 1'b0;
  endtask

  task automatic step(input bit v, input int d, input bit ordy);
    longint act;
    longint e;
    int     c;
    @(negedge clk);
    in_valid  = v;
    in_data   = d[DW-1:0];
    out_ready = ordy;
    #1;
    act = longint'($signed(out_data));
    if (prev_stall)
      check(out_valid && (out_data == prev_data), "R6 held output", act, longint'($signed(prev_data)));
    check(in_ready == (ordy || !out_valid), "R7 ready rule", longint'(in_ready), longint'(ordy || !out_valid));
    if (out_valid && ordy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected output", act, 0);
      end else begin
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        check(act == e, cur_req, act, e);
        if (lat_on) check(cyc - c == LAT, "R3 latency", longint'(cyc - c), longint'(LAT));
      end
    end
    if (v && in_ready) begin
      for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'($signed(d[DW-1:0]));
      e = 0;
      for (int k = 0; k < N; k++) e += longint'(cf[k]) * hist[k];
      exp_q.push_back(e);
      cyc_q.push_back(cyc);
    end
    prev_stall = out_valid && !ordy;
    prev_data  = out_data;
    cyc++;
  endtask

  task automatic drain();
    repeat (LAT + 3) step(1'b0, 0, 1'b1);
    check(exp_q.size() == 0, "R3 all results delivered", longint'(exp_q.size()), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_data = '0;
    repeat (2) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1 R7 ready after reset", longint'(in_ready), 1);
    rst = 1'b0;
    clear_model();
  endtask

  task automatic t_impulse();
    cf[0] = 3; cf[1] = -5; cf[2] = 7; cf[3] = -11; cf[4] = 13;
    cur_req = "R8 impulse response"; lat_on = 1'b1;
    step(1'b1, 1, 1'b1);
    repeat (N + 2) step(1'b1, 0, 1'b1);
    drain();
  endtask

  task automatic t_stream();
    cf[0] = -2; cf[1] = 9; cf[2] = 4; cf[3] = -7; cf[4] = 1;
    cur_req = "R2 dot product"; lat_on = 1'b1;
    for (int i = 0; i < 40; i++) step(1'b1, ((i * 37 + 11) % 256) - 128, 1'b1);
    drain();
  endtask

  task automatic t_extreme();
    cur_req = "R4 full precision"; lat_on = 1'b1;
    for (int k = 0; k < N; k++) cf[k] = -128;
    repeat (N + 1) step(1'b1, -128, 1'b1);
    drain();
    for (int k = 0; k < N; k++) cf[k] = 127;
    repeat (N + 1) step(1'b1, -128, 1'b1);
    drain();
    for (int k = 0; k < N; k++) cf[k] = (k % 2 == 0) ? -128 : 127;
    for (int i = 0; i < 12; i++) step(1'b1, (i % 2 == 0) ? 127 : -128, 1'b1);
    drain();
  endtask

  task automatic t_bubbles();
    cf[0] = 5; cf[1] = -3; cf[2] = 2; cf[3] = 6; cf[4] = -1;
    cur_req = "R5 bubbles ignored"; lat_on = 1'b1;
    for (int i = 0; i < 30; i++) begin
      if (i % 3 == 1) step(1'b0, 99, 1'b1);
      else            step(1'b1, (i * 13) % 50 - 25, 1'b1);
    end
    drain();
  endtask

  task automatic t_backpressure();
    cf[0] = 1; cf[1] = 2; cf[2] = -3; cf[3] = 4; cf[4] = -5;
    cur_req = "R6 order under stall"; lat_on = 1'b0;
    for (int i = 0; i < 36; i++) step(1'b1, (i * 29) % 90 - 45, (i % 4) != 1 && (i % 7) != 3);
    repeat (3) step(1'b1, 17, 1'b0);
    drain();
  endtask

  task automatic t_reset_mid();
    cf[0] = 10; cf[1] = 20; cf[2] = 30; cf[3] = 40; cf[4] = 50;
    lat_on = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 60 + i, 1'b1);
    t_reset();
    cur_req = "R1 history cleared";
    step(1'b1, 2, 1'b1);
    repeat (N + 1) step(1'b0, 0, 1'b1);
    drain();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; done = 1'b0;
    for (int k = 0; k < N; k++) cf[k] = 0;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    lat_on = 1'b0; cur_req = "R2";
    clear_model();
    t_reset();
    t_impulse();
    t_stream();
    t_extreme();
    t_bubbles();
    t_backpressure();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule